// File: doc/BRIEF.md
# CEC Wake-on-Message Filter

This block sits behind the byte assembler of a CEC receiver and stays powered while the rest of the system sleeps. It watches each received frame as a stream of bytes. The first byte of a frame carries a start flag, and the last byte carries an end-of-message flag. When a finished frame carries one of the programmed opcodes, and that opcode is addressed to the device's own physical address, the block latches a wake event. When the event is unmasked, it raises a wake request.

The filter is set up before sleep through a small word-wide register port. That port holds the arm control, a set of opcode slots each with its own enable bit, the local physical address, a wake mask and a write-1-to-clear wake status. Every register can be read back through a separate combinational read port. The frame header byte holds the initiator address in its upper nibble and the destination in its lower nibble (0xF is broadcast). The header is passed through and takes no part in the comparison.

Top module: `cec_wake_filter`

## Requirements
- R1: After reset, wake_req is 0 and every register reads 0.
- R2: Register map by word address: 0 = arm control (bit 0); 1 and 2 = opcode slots; 3 = physical address (bits 15:0); 4 = wake mask; 5 = wake status. Each opcode slot keeps its enable in bit 31 and its opcode in bits 7:0. Only the defined bits are stored, and all other bits read 0.
- R3: A frame that is at least four bytes long matches when byte 1 equals the opcode of an enabled slot and bytes 2 and 3 equal the programmed address. The match is evaluated on the byte that carries end-of-message, and it sets wake status bit 18 on that same clock edge.
- R4: The address register holds the host's 16-bit address with its bytes swapped. Register bits 7:0 are compared with frame byte 2, and bits 15:8 with frame byte 3.
- R5: A slot whose bit 31 is 0 never matches, even when its opcode equals byte 1.
- R6: A frame of one, two or three bytes never matches.
- R7: A start flag that arrives before end-of-message discards the unfinished frame. The new frame is then judged on its own bytes only.
- R8: While arm control bit 0 is 0, received bytes are ignored. Writing 0 abandons any frame in progress, and writing 1 re-arms the filter for the next start flag.
- R9: wake_req is high exactly when status bit 18 and mask bit 18 are both 1. It stays high until one of them is cleared.
- R10: Writing to the status register clears bit 18 only where the written data has bit 18 set. If a match and a clear happen in the same cycle, the match wins.
- R11: Bytes without a start flag that arrive outside a frame are ignored.
- R12: A frame whose opcode matches no slot, or whose address bytes differ from the programmed address, leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 3 | Register write word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 3 | Register read word address |
| cfg_rdata | output | 32 | Register read data (combinational) |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eom | input | 1 | Byte is the last of a frame |
| wake_req | output | 1 | Wake request |

## Verification
The hardest cases to reach are those where the tracker could be fooled by the bytes it has already seen. One case is a frame that restarts after three good bytes, so that a tracker which ignored the restart would see a matching five-byte frame. Another is an arm toggle in the middle of a frame that would otherwise match. A third is a match arriving on the same edge as a status clear. The bench builds each of these with directed byte sequences and timed register writes. A behavioural queue model tracks both the status and the readback on every clock.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  localparam int BYTE_W      = 8;
  localparam int PA_W        = 16;
  localparam int REG_W       = 32;
  localparam int WAKE_BIT    = 18;
  localparam int SLOT_EN_BIT = 31;
  localparam int A_CTRL      = 0;
  localparam int A_SLOT_BASE = 1;

  function automatic int addr_pa(input int n_slots);
    return A_SLOT_BASE + n_slots;
  endfunction

  function automatic int addr_mask(input int n_slots);
    return A_SLOT_BASE + n_slots + 1;
  endfunction

  function automatic int addr_stat(input int n_slots);
    return A_SLOT_BASE + n_slots + 2;
  endfunction

  // one opcode slot against the frame's opcode byte
  function automatic logic slot_hit(input logic en, input logic [BYTE_W-1:0] op,
                                    input logic [BYTE_W-1:0] frm_op);
    return en && (op == frm_op);
  endfunction

  // swapped address register: low byte meets frame byte 2, high byte meets byte 3
  function automatic logic pa_hit(input logic [PA_W-1:0] pa_reg,
                                  input logic [BYTE_W-1:0] frm_b2,
                                  input logic [BYTE_W-1:0] frm_b3);
    return (pa_reg[7:0] == frm_b2) && (pa_reg[15:8] == frm_b3);
  endfunction
endpackage

// File: rtl/cwf_regs.sv
module cwf_regs
  import cwf_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int ADDR_W    = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [ADDR_W-1:0]                waddr,
  input  logic [REG_W-1:0]                 wdata,
  input  logic [ADDR_W-1:0]                raddr,
  input  logic                             match_evt,
  output logic [REG_W-1:0]                 rdata,
  output logic                             arm,
  output logic [NUM_SLOTS-1:0]             slot_en,
  output logic [NUM_SLOTS-1:0][BYTE_W-1:0] slot_op,
  output logic [PA_W-1:0]                  pa_reg,
  output logic                             mask_bit,
  output logic                             stat_bit,
  output logic                             clr_evt,
  output logic                             mask_wr_evt
);
  localparam logic [ADDR_W-1:0] A_CTRL_L = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] A_PA_L   = ADDR_W'(addr_pa(NUM_SLOTS));
  localparam logic [ADDR_W-1:0] A_MASK_L = ADDR_W'(addr_mask(NUM_SLOTS));
  localparam logic [ADDR_W-1:0] A_STAT_L = ADDR_W'(addr_stat(NUM_SLOTS));

  logic wdata_unused;
  assign wdata_unused = ^wdata;

  assign clr_evt     = we && (waddr == A_STAT_L) && wdata[WAKE_BIT];
  assign mask_wr_evt = we && (waddr == A_MASK_L);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm      <= 1'b0;
      pa_reg   <= '0;
      mask_bit <= 1'b0;
      stat_bit <= 1'b0;
    end else begin
      if (we && waddr == A_CTRL_L) arm <= wdata[0];
      if (we && waddr == A_PA_L)   pa_reg <= wdata[PA_W-1:0];
      if (mask_wr_evt)             mask_bit <= wdata[WAKE_BIT];
      stat_bit <= (stat_bit && !clr_evt) || match_evt;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [ADDR_W-1:0] A_S = ADDR_W'(A_SLOT_BASE + s);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_en[s] <= 1'b0;
        slot_op[s] <= '0;
      end else if (we && waddr == A_S) begin
        slot_en[s] <= wdata[SLOT_EN_BIT];
        slot_op[s] <= wdata[BYTE_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (raddr == A_CTRL_L) rdata[0] = arm;
    if (raddr == A_PA_L)   rdata[PA_W-1:0] = pa_reg;
    if (raddr == A_MASK_L) rdata[WAKE_BIT] = mask_bit;
    if (raddr == A_STAT_L) rdata[WAKE_BIT] = stat_bit;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (int'(raddr) == A_SLOT_BASE + s) begin
        rdata[SLOT_EN_BIT]  = slot_en[s];
        rdata[BYTE_W-1:0]   = slot_op[s];
      end
    end
  end
endmodule

// File: rtl/cwf_frame_track.sv
module cwf_frame_track
  import cwf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_sof,
  input  logic              rx_eom,
  output logic              frame_end,
  output logic              len_ok,
  output logic [BYTE_W-1:0] f_op,
  output logic [BYTE_W-1:0] f_b2,
  output logic [BYTE_W-1:0] f_b3
);
  // cnt: 0 = outside a frame, else bytes seen so far (saturates at 4)
  logic [2:0]        cnt;
  logic [BYTE_W-1:0] r_op, r_b2, r_b3;
  logic              accept, start, cont;

  assign accept = arm && rx_valid;
  assign start  = accept && rx_sof;
  assign cont   = accept && !rx_sof && (cnt != 3'd0);

  assign f_op = (cont && cnt == 3'd1) ? rx_byte : r_op;
  assign f_b2 = (cont && cnt == 3'd2) ? rx_byte : r_b2;
  assign f_b3 = (cont && cnt == 3'd3) ? rx_byte : r_b3;

  assign frame_end = (start || cont) && rx_eom;
  assign len_ok    = cont && (cnt >= 3'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= 3'd0;
      r_op <= '0;
      r_b2 <= '0;
      r_b3 <= '0;
    end else if (!arm) begin
      cnt <= 3'd0;
    end else begin
      if (start)     cnt <= rx_eom ? 3'd0 : 3'd1;
      else if (cont) cnt <= rx_eom ? 3'd0 : ((cnt == 3'd4) ? 3'd4 : cnt + 3'd1);
      r_op <= f_op;
      r_b2 <= f_b2;
      r_b3 <= f_b3;
    end
  end
endmodule

// File: rtl/cwf_match.sv
module cwf_match
  import cwf_pkg::*;
#(
  parameter int NUM_SLOTS = 2
) (
  input  logic                             frame_end,
  input  logic                             len_ok,
  input  logic [BYTE_W-1:0]                f_op,
  input  logic [BYTE_W-1:0]                f_b2,
  input  logic [BYTE_W-1:0]                f_b3,
  input  logic [NUM_SLOTS-1:0]             slot_en,
  input  logic [NUM_SLOTS-1:0][BYTE_W-1:0] slot_op,
  input  logic [PA_W-1:0]                  pa_reg,
  output logic                             op_hit,
  output logic                             match_evt
);
  always_comb begin
    op_hit = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++)
      op_hit = op_hit | slot_hit(slot_en[s], slot_op[s], f_op);
  end

  assign match_evt = frame_end && len_ok && op_hit && pa_hit(pa_reg, f_b2, f_b3);
endmodule

// File: rtl/cec_wake_filter.sv
module cec_wake_filter
  import cwf_pkg::*;
#(
  parameter  int NUM_SLOTS = 2,
  localparam int ADDR_W    = $clog2(NUM_SLOTS + 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_waddr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [ADDR_W-1:0] cfg_raddr,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_sof,
  input  logic              rx_eom,
  output logic              wake_req
);
  logic                             arm, mask_bit, stat_bit, clr_evt, mask_wr_evt;
  logic [NUM_SLOTS-1:0]             slot_en;
  logic [NUM_SLOTS-1:0][BYTE_W-1:0] slot_op;
  logic [PA_W-1:0]                  pa_reg;
  logic                             frame_end, len_ok, op_hit, match_evt;
  logic [BYTE_W-1:0]                f_op, f_b2, f_b3;
  logic                             op_hit_unused;

  assign op_hit_unused = op_hit;

  cwf_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
    .raddr(cfg_raddr), .match_evt(match_evt), .rdata(cfg_rdata), .arm(arm),
    .slot_en(slot_en), .slot_op(slot_op), .pa_reg(pa_reg), .mask_bit(mask_bit),
    .stat_bit(stat_bit), .clr_evt(clr_evt), .mask_wr_evt(mask_wr_evt)
  );

  cwf_frame_track u_track (
    .clk(clk), .rst_n(rst_n), .arm(arm), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_sof(rx_sof), .rx_eom(rx_eom), .frame_end(frame_end), .len_ok(len_ok),
    .f_op(f_op), .f_b2(f_b2), .f_b3(f_b3)
  );

  cwf_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
    .frame_end(frame_end), .len_ok(len_ok), .f_op(f_op), .f_b2(f_b2), .f_b3(f_b3),
    .slot_en(slot_en), .slot_op(slot_op), .pa_reg(pa_reg), .op_hit(op_hit),
    .match_evt(match_evt)
  );

  assign wake_req = stat_bit && mask_bit;
endmodule

// File: rtl/cwf_checker.sv
module cwf_checker (
  input logic clk,
  input logic rst_n,
  input logic match_evt,
  input logic arm,
  input logic stat_bit,
  input logic clr_evt,
  input logic mask_wr_evt,
  input logic rx_valid,
  input logic rx_eom,
  input logic wake_req
);
  // R3: a match is latched into the status on the accepting edge
  assert_match_sets_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> stat_bit);

  // R3: a match only ever comes from an end-of-message byte at the port
  assert_match_at_eom_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |-> (rx_valid && rx_eom));

  // R8: a disarmed filter produces no match
  assert_no_match_disarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |-> arm);

  // R10: status is sticky until a clear write
  assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_bit && !clr_evt) |=> stat_bit);

  // R9: the request holds while neither status nor mask is touched
  assert_wake_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !clr_evt && !mask_wr_evt) |=> wake_req);
endmodule

bind cec_wake_filter cwf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .match_evt(match_evt), .arm(arm), .stat_bit(stat_bit),
  .clr_evt(clr_evt), .mask_wr_evt(mask_wr_evt), .rx_valid(rx_valid), .rx_eom(rx_eom),
  .wake_req(wake_req)
);

// File: tb/sim_cec_wake_filter.sv
module sim_cec_wake_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_waddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_sof = 1'b0;
  logic        rx_eom = 1'b0;
  logic        wake_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cec_wake_filter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_sof(rx_sof), .rx_eom(rx_eom),
    .wake_req(wake_req)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] q[$];
  bit         in_frame;
  bit         m_arm, m_mask, m_stat;
  bit         m_en[2];
  logic [7:0] m_op[2];
  logic [15:0] m_pa;

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_arm};
      3'd1: return {m_en[0], 23'd0, m_op[0]};
      3'd2: return {m_en[1], 23'd0, m_op[1]};
      3'd3: return {16'd0, m_pa};
      3'd4: return 32'(m_mask) << 18;
      3'd5: return 32'(m_stat) << 18;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit hit;
    bit clr;
    logic [15:0] host;
    if (!rst_n) begin
      q.delete(); in_frame = 0; m_arm = 0; m_mask = 0; m_stat = 0;
      m_en[0] = 0; m_en[1] = 0; m_op[0] = 0; m_op[1] = 0; m_pa = 0;
    end else begin
      hit = 0;
      if (!m_arm) begin
        in_frame = 0; q.delete();
      end else if (rx_valid) begin
        if (rx_sof) begin q.delete(); q.push_back(rx_byte); in_frame = 1; end
        else if (in_frame) q.push_back(rx_byte);
        if (rx_eom && in_frame) begin
          host = {m_pa[7:0], m_pa[15:8]};
          if (q.size() >= 4 &&
              ((m_en[0] && q[1] == m_op[0]) || (m_en[1] && q[1] == m_op[1])) &&
              {q[2], q[3]} == host)
            hit = 1;
          in_frame = 0; q.delete();
        end
      end
      clr = 0;
      if (cfg_we) begin
        case (cfg_waddr)
          3'd0: m_arm = cfg_wdata[0];
          3'd1: begin m_en[0] = cfg_wdata[31]; m_op[0] = cfg_wdata[7:0]; end
          3'd2: begin m_en[1] = cfg_wdata[31]; m_op[1] = cfg_wdata[7:0]; end
          3'd3: m_pa = cfg_wdata[15:0];
          3'd4: m_mask = cfg_wdata[18];
          3'd5: clr = cfg_wdata[18];
          default: ;
        endcase
      end
      m_stat = (m_stat && !clr) || hit;
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (wake_req !== (m_stat && m_mask)) begin
        errors++;
        $display("FAIL R9 model wake_req actual=%0b expected=%0b", wake_req, m_stat && m_mask);
      end
      checks++;
      if (cfg_rdata !== m_read(cfg_raddr)) begin
        errors++;
        $display("FAIL R2 model readback addr=%0d actual=%h expected=%h",
                 cfg_raddr, cfg_rdata, m_read(cfg_raddr));
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_raddr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic sb(input logic [7:0] b, input bit sof, input bit eom);
    @(negedge clk);
    rx_valid = 1; rx_byte = b; rx_sof = sof; rx_eom = eom;
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eom = 0;
  endtask

  task automatic frame4(input logic [7:0] b0, b1, b2, b3);
    sb(b0, 1, 0); sb(b1, 0, 0); sb(b2, 0, 0); sb(b3, 0, 1);
  endtask

  task automatic clear_stat();
    wr(3'd5, 32'h0004_0000);
  endtask

  logic [31:0] rv;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 wake_req", {31'd0, wake_req}, 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), rv);
      chk("R1 reg reset", rv, 0);
    end

    // R2 configuration and readback
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FF86);
    wr(3'd2, 32'h8000_0080);
    wr(3'd3, 32'hABCD_3412);          // host 0x1234, swapped
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd0, rv); chk("R2 ctrl", rv, 32'h1);
    rd(3'd1, rv); chk("R2 slot0", rv, 32'h8000_0086);
    rd(3'd3, rv); chk("R2 addr", rv, 32'h0000_3412);
    rd(3'd4, rv); chk("R2 mask", rv, 32'h0004_0000);
    rd(3'd5, rv); chk("R2 status", rv, 32'h0);

    // R3/R4 matching frame; nothing before end-of-message
    sb(8'h4F, 1, 0); sb(8'h86, 0, 0); sb(8'h12, 0, 0);
    chk("R3 no wake before eom", {31'd0, wake_req}, 0);
    sb(8'h34, 0, 1);
    chk("R3 wake on match", {31'd0, wake_req}, 1);
    rd(3'd5, rv); chk("R3 status bit18", rv, 32'h0004_0000);

    // R10 write zero keeps, write one clears
    wr(3'd5, 32'hFFFB_FFFF);
    chk("R10 zero write keeps", {31'd0, wake_req}, 1);
    clear_stat();
    chk("R10 one write clears", {31'd0, wake_req}, 0);

    // R4 address bytes in the wrong order
    frame4(8'h4F, 8'h86, 8'h34, 8'h12);
    chk("R4 swapped order no match", {31'd0, wake_req}, 0);

    // R3 second slot, broadcast header
    frame4(8'h0F, 8'h80, 8'h12, 8'h34);
    chk("R3 slot1 match", {31'd0, wake_req}, 1);
    clear_stat();

    // R12 mismatches
    frame4(8'h4F, 8'h82, 8'h12, 8'h34);
    chk("R12 opcode mismatch", {31'd0, wake_req}, 0);
    frame4(8'h4F, 8'h86, 8'h12, 8'h35);
    chk("R12 address mismatch", {31'd0, wake_req}, 0);

    // R5 disabled slot
    wr(3'd2, 32'h0000_0080);
    frame4(8'h4F, 8'h80, 8'h12, 8'h34);
    chk("R5 disabled slot", {31'd0, wake_req}, 0);
    wr(3'd2, 32'h8000_0080);

    // R6 short frames
    sb(8'h4F, 1, 0); sb(8'h86, 0, 0); sb(8'h12, 0, 1);
    chk("R6 three byte frame", {31'd0, wake_req}, 0);
    sb(8'h4F, 1, 1);
    chk("R6 one byte frame", {31'd0, wake_req}, 0);

    // R7 restart before eom
    sb(8'h4F, 1, 0); sb(8'h86, 0, 0); sb(8'h12, 0, 0);
    sb(8'h34, 1, 0); sb(8'h86, 0, 1);
    chk("R7 restart discards", {31'd0, wake_req}, 0);
    sb(8'h4F, 1, 0); sb(8'h86, 0, 0);
    frame4(8'h4F, 8'h86, 8'h12, 8'h34);
    chk("R7 new frame judged alone", {31'd0, wake_req}, 1);
    clear_stat();

    // R11 bytes outside a frame
    sb(8'h4F, 0, 0); sb(8'h86, 0, 0); sb(8'h12, 0, 0); sb(8'h34, 0, 1);
    chk("R11 no start flag", {31'd0, wake_req}, 0);

    // R8 re-arm mid frame, and disarmed
    sb(8'h4F, 1, 0); sb(8'h86, 0, 0);
    wr(3'd0, 32'h0); wr(3'd0, 32'h1);
    sb(8'h12, 0, 0); sb(8'h34, 0, 1);
    chk("R8 rearm abandons frame", {31'd0, wake_req}, 0);
    wr(3'd0, 32'h0);
    frame4(8'h4F, 8'h86, 8'h12, 8'h34);
    chk("R8 disarmed ignores", {31'd0, wake_req}, 0);
    wr(3'd0, 32'h1);

    // R9 masking
    wr(3'd4, 32'h0);
    frame4(8'h4F, 8'h86, 8'h12, 8'h34);
    chk("R9 masked no wake", {31'd0, wake_req}, 0);
    rd(3'd5, rv); chk("R9 status still set", rv, 32'h0004_0000);
    wr(3'd4, 32'h0004_0000);
    chk("R9 unmask raises", {31'd0, wake_req}, 1);
    repeat (5) @(negedge clk);
    chk("R9 held", {31'd0, wake_req}, 1);
    clear_stat();

    // R10 match and clear on the same edge
    sb(8'h4F, 1, 0); sb(8'h86, 0, 0); sb(8'h12, 0, 0);
    @(negedge clk);
    rx_valid = 1; rx_byte = 8'h34; rx_sof = 0; rx_eom = 1;
    cfg_we = 1; cfg_waddr = 3'd5; cfg_wdata = 32'h0004_0000;
    @(negedge clk);
    rx_valid = 0; rx_eom = 0; cfg_we = 0;
    chk("R10 set wins over clear", {31'd0, wake_req}, 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule